// File: doc/BRIEF.md
# Inhibitable Position Output Latch with Byte Lanes

This block sits between a free-running position counter and a shared parallel data bus. It keeps a holding register that follows the counter: the register copies the counter word at the end of each counter update strobe. A host that wants a stable reading pulls the inhibit input low. This freezes only the copy from counter to register, and the counter keeps running on its own side. A fixed number of clock cycles after inhibit goes low, a valid flag rises. The host then reads the frozen word and releases inhibit. On release the block sends a one-cycle refresh pulse back to the counter side, and on that pulse the register picks up the current count.

The word leaves the block on two 8-bit lanes. Each lane has its own output-enable, which the pad drivers outside the block use. The second lane always carries the low byte. A byte-select input sets what the first lane carries: the high byte, or a copy of the low byte, so that an 8-bit host can read the word in two passes. A 2-bit resolution code says how many of the 16 bits are significant. The word is aligned to the most significant bit, and the unused low-order bits are driven as zero.

Top module: `pol_bus_latch`

## Requirements
- R1: After reset both lanes read zero and valid and refresh are low. While inhibit (`hold_n_i`) is high, the cycle in which `busy_i` is sampled high and then low loads `count_i` into the holding register. The new value appears on the lanes after that clock edge. A `busy_i` that stays high loads nothing until it falls.
- R2: While `hold_n_i` is low, a `busy_i` pulse does not change the lanes. The counter side keeps running unaffected.
- R3: When `hold_n_i` returns high, `refresh_o` is high for exactly one cycle, starting one clock edge later. The edge on which it is high loads the current `count_i` into the register.
- R4: `valid_o` rises exactly VALID_DLY clock edges after `hold_n_i` is sampled low. It is low whenever `hold_n_i` is high.
- R5: Both output-enables are high when `oe_n_i` is 0 and low when it is 1. The enable has no effect on the lane data or on loading.
- R6: `lane_b_o` always carries bits 7:0 of the driven word.
- R7: When `hi_sel_i` is 1, `lane_a_o` carries bits 15:8. When it is 0, `lane_a_o` equals `lane_b_o`.
- R8: Resolution code 0, 1, 2 and 3 selects 10, 12, 14 and 16 significant bits. The lowest 6, 4, 2 or 0 bits of the driven word are zero. With the default MASK_AT_OUTPUT=1, a change of code takes effect on the lanes at once, without a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 16 | Live counter word, MSB-aligned |
| busy_i | input | 1 | Counter update strobe; load on its falling edge |
| hold_n_i | input | 1 | Inhibit, active low: low freezes the register |
| oe_n_i | input | 1 | Output enable, active low |
| hi_sel_i | input | 1 | Byte select for lane A (1 = high byte) |
| res_code_i | input | 2 | Resolution code (0..3 = 10..16 bits) |
| lane_a_o | output | 8 | Lane A data |
| lane_a_oe_o | output | 1 | Lane A drive enable |
| lane_b_o | output | 8 | Lane B data, always low byte |
| lane_b_oe_o | output | 1 | Lane B drive enable |
| valid_o | output | 1 | Frozen data is ready to read |
| refresh_o | output | 1 | One-cycle refresh request on inhibit release |

## Verification
The load path is swept over every resolution code, with a set of scattered data words under both byte-select values. A wrong lane routing, a wrong mask width or a mask at the wrong end of the word each give a different mismatch. An all-ones word is then held while the code changes. This separates masking at the output from masking at capture. Busy pulses given while inhibit is low, and a busy strobe held high for several cycles, show whether loading happens at the wrong moment. A release of inhibit with a fresh count, with the valid flag sampled one cycle either side of the expected edge, checks the refresh pulse width and the delay count.

// File: rtl/pol_pkg.sv
`timescale 1ns/1ps
package pol_pkg;
   typedef enum logic [1:0] {
      RES_MIN  = 2'd0,
      RES_LO   = 2'd1,
      RES_HI   = 2'd2,
      RES_FULL = 2'd3
   } res_code_e;
   localparam int RES_STEP  = 2;
   localparam int RES_CODES = 4;
endpackage

// File: rtl/pol_strobe_gen.sv
`timescale 1ns/1ps
module pol_strobe_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic hold_n_i,
   output logic load_o,
   output logic refresh_o
);
   logic busy_q;
   logic hold_q;
   logic refresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         hold_q    <= 1'b1;
         refresh_q <= 1'b0;
      end else begin
         busy_q    <= busy_i;
         hold_q    <= hold_n_i;
         refresh_q <= hold_n_i & ~hold_q;
      end
   end

   assign load_o    = (busy_q & ~busy_i & hold_n_i) | refresh_q;
   assign refresh_o = refresh_q;

   AST_REFRESH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_q |=> !refresh_q); // R3
   AST_REFRESH_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_n_i) |=> refresh_q); // R3
endmodule

// File: rtl/pol_valid_timer.sv
`timescale 1ns/1ps
module pol_valid_timer #(
   parameter int VALID_DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_n_i,
   output logic valid_o
);
   localparam int DLY_W = $clog2(VALID_DLY + 1);
   localparam logic [DLY_W-1:0] DLY_END = DLY_W'(VALID_DLY);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || hold_n_i) cnt_q <= '0;
      else if (cnt_q != DLY_END) cnt_q <= cnt_q + 1'b1;
   end

   assign valid_o = !hold_n_i && (cnt_q == DLY_END);

   AST_VALID_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !hold_n_i); // R4
   AST_VALID_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(!hold_n_i)); // R4
endmodule

// File: rtl/pol_lane_mux.sv
`timescale 1ns/1ps
module pol_lane_mux #(
   parameter int LANE_W = 8
) (
   input  logic [2*LANE_W-1:0] word_i,
   input  logic                hi_sel_i,
   output logic [LANE_W-1:0]   lane_a_o,
   output logic [LANE_W-1:0]   lane_b_o
);
   logic [LANE_W-1:0] lane_hi;
   logic [LANE_W-1:0] lane_lo;

   assign lane_hi  = word_i[2*LANE_W-1:LANE_W];
   assign lane_lo  = word_i[LANE_W-1:0];
   assign lane_b_o = lane_lo;
   assign lane_a_o = hi_sel_i ? lane_hi : lane_lo;

   always_comb begin
      if (!hi_sel_i) AST_LANE_COPY: assert (lane_a_o == lane_b_o); // R7
   end
endmodule

// File: rtl/pol_bus_latch.sv
`timescale 1ns/1ps
module pol_bus_latch #(
   parameter int WORD_W         = 16,
   parameter int LANE_W         = 8,
   parameter int VALID_DLY      = 4,
   parameter bit MASK_AT_OUTPUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] count_i,
   input  logic              busy_i,
   input  logic              hold_n_i,
   input  logic              oe_n_i,
   input  logic              hi_sel_i,
   input  logic [1:0]        res_code_i,
   output logic [LANE_W-1:0] lane_a_o,
   output logic              lane_a_oe_o,
   output logic [LANE_W-1:0] lane_b_o,
   output logic              lane_b_oe_o,
   output logic              valid_o,
   output logic              refresh_o
);
   import pol_pkg::*;

   localparam int MAX_CODE  = RES_CODES - 1;
   localparam int MIN_RES   = WORD_W - MAX_CODE * RES_STEP;

   generate
      if (WORD_W != 2 * LANE_W) begin : g_bad_width
         $error("pol_bus_latch: WORD_W must be twice LANE_W");
      end
      if (MIN_RES < 1) begin : g_bad_res
         $error("pol_bus_latch: WORD_W too narrow for the resolution codes");
      end
      if (VALID_DLY < 1) begin : g_bad_dly
         $error("pol_bus_latch: VALID_DLY must be at least 1");
      end
   endgenerate

   res_code_e         res_code;
   logic [WORD_W-1:0] res_mask;
   logic [WORD_W-1:0] latch_q;
   logic [WORD_W-1:0] drv_word;
   logic              load;
   logic              refresh;

   assign res_code = res_code_e'(res_code_i);

   always_comb begin
      int shamt;
      shamt    = (MAX_CODE - int'(res_code)) * RES_STEP;
      res_mask = {WORD_W{1'b1}} << shamt;
   end

   pol_strobe_gen u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_i    (busy_i),
      .hold_n_i  (hold_n_i),
      .load_o    (load),
      .refresh_o (refresh)
   );

   pol_valid_timer #(.VALID_DLY(VALID_DLY)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_n_i (hold_n_i),
      .valid_o  (valid_o)
   );

   generate
      if (MASK_AT_OUTPUT) begin : g_mask_out
         always_ff @(posedge clk) begin
            if (!rst_n)    latch_q <= '0;
            else if (load) latch_q <= count_i;
         end
         assign drv_word = latch_q & res_mask;
      end else begin : g_mask_cap
         always_ff @(posedge clk) begin
            if (!rst_n)    latch_q <= '0;
            else if (load) latch_q <= count_i & res_mask;
         end
         assign drv_word = latch_q;
      end
   endgenerate

   pol_lane_mux #(.LANE_W(LANE_W)) u_mux (
      .word_i   (drv_word),
      .hi_sel_i (hi_sel_i),
      .lane_a_o (lane_a_o),
      .lane_b_o (lane_b_o)
   );

   assign lane_a_oe_o = ~oe_n_i;
   assign lane_b_oe_o = ~oe_n_i;
   assign refresh_o   = refresh;

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_n_i && !refresh) |=> $stable(latch_q)); // R2
   AST_OE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      lane_a_oe_o == lane_b_oe_o); // R5
   AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_code == RES_MIN) |-> ({lane_b_o[5:0]} == 6'd0)); // R8
   AST_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      hi_sel_i |-> (lane_a_o == drv_word[WORD_W-1:LANE_W])); // R7
endmodule

// File: tb/pol_bus_latch_bench.sv
`timescale 1ns/1ps
module pol_bus_latch_bench;
   localparam int DLY = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] count_i;
   logic        busy_i, hold_n_i, oe_n_i, hi_sel_i;
   logic [1:0]  res_code_i;
   logic [7:0]  lane_a_o, lane_b_o;
   logic        lane_a_oe_o, lane_b_oe_o, valid_o, refresh_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pol_bus_latch #(.VALID_DLY(DLY)) u_pol_bus_latch (
      .clk(clk), .rst_n(rst_n), .count_i(count_i), .busy_i(busy_i),
      .hold_n_i(hold_n_i), .oe_n_i(oe_n_i), .hi_sel_i(hi_sel_i),
      .res_code_i(res_code_i), .lane_a_o(lane_a_o), .lane_a_oe_o(lane_a_oe_o),
      .lane_b_o(lane_b_o), .lane_b_oe_o(lane_b_oe_o), .valid_o(valid_o),
      .refresh_o(refresh_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mask_of(input int code);
      return 16'hFFFF << ((3 - code) * 2);
   endfunction

   task automatic pulse_busy(input logic [15:0] v);
      @(negedge clk); count_i = v; busy_i = 1'b1;
      @(negedge clk); busy_i = 1'b0;
      @(negedge clk); #1;
   endtask

   task automatic chk_word(input string req, input logic [15:0] exp);
      hi_sel_i = 1'b1; #1;
      chk({req, " hi lane_a"}, {8'h00, lane_a_o}, {8'h00, exp[15:8]});
      chk({req, " lane_b"},    {8'h00, lane_b_o}, {8'h00, exp[7:0]});
      hi_sel_i = 1'b0; #1;
      chk({req, " lo lane_a"}, {8'h00, lane_a_o}, {8'h00, exp[7:0]});
      hi_sel_i = 1'b1; #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; count_i = '0; busy_i = 1'b0; hold_n_i = 1'b1;
      oe_n_i = 1'b0; hi_sel_i = 1'b1; res_code_i = 2'd3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; #1;
      // R1 reset state
      chk("R1 reset lanes", {lane_a_o, lane_b_o}, 16'h0000);
      chk("R1 reset valid/refresh", {14'd0, valid_o, refresh_o}, 16'h0000);

      // R1 R6 R7 R8 sweep over codes, words and byte select
      for (int code = 0; code < 4; code++) begin
         res_code_i = 2'(code);
         for (int i = 0; i < 8; i++) begin
            logic [15:0] v;
            v = 16'(16'h9E37 * (i + 1)) ^ 16'(code * 16'h0F0F);
            pulse_busy(v);
            chk_word("R1_R6_R7_R8 sweep", v & mask_of(code));
         end
      end

      // R8 immediate code change with all-ones word
      res_code_i = 2'd3;
      pulse_busy(16'hFFFF);
      for (int code = 0; code < 4; code++) begin
         res_code_i = 2'(code); #1;
         chk_word("R8 code change", mask_of(code));
      end
      res_code_i = 2'd3;

      // R1 busy held high: no load until it falls
      pulse_busy(16'h1234);
      @(negedge clk); count_i = 16'hAAAA; busy_i = 1'b1;
      @(negedge clk); count_i = 16'hBBBB;
      @(negedge clk); count_i = 16'hCCCC; #1;
      chk_word("R1 busy held", 16'h1234);
      busy_i = 1'b0;
      @(negedge clk); #1;
      chk_word("R1 busy fall", 16'hCCCC);

      // R5 enable
      oe_n_i = 1'b1; #1;
      chk("R5 oe off", {14'd0, lane_a_oe_o, lane_b_oe_o}, 16'h0000);
      chk_word("R5 data with oe off", 16'hCCCC);
      pulse_busy(16'h5A5A);
      chk_word("R5 load with oe off", 16'h5A5A);
      oe_n_i = 1'b0; #1;
      chk("R5 oe on", {14'd0, lane_a_oe_o, lane_b_oe_o}, 16'h0003);

      // R4 valid delay, R2 freeze
      @(negedge clk); hold_n_i = 1'b0; #1;
      for (int k = 1; k <= DLY; k++) begin
         @(negedge clk); #1;
         chk("R4 valid timing", {15'd0, valid_o}, (k == DLY) ? 16'd1 : 16'd0);
      end
      pulse_busy(16'h0F0F);
      pulse_busy(16'h7777);
      chk_word("R2 frozen", 16'h5A5A);
      chk("R4 valid held", {15'd0, valid_o}, 16'd1);

      // R3 release and refresh
      @(negedge clk); count_i = 16'hE1E1; hold_n_i = 1'b1; #1;
      chk("R4 valid drop", {15'd0, valid_o}, 16'd0);
      chk("R3 no early refresh", {15'd0, refresh_o}, 16'd0);
      @(negedge clk); #1;
      chk("R3 refresh high", {15'd0, refresh_o}, 16'd1);
      @(negedge clk); #1;
      chk("R3 refresh single", {15'd0, refresh_o}, 16'd0);
      chk_word("R3 refresh load", 16'hE1E1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule